// File: doc/BRIEF.md
# Watermarked Multi-Mode Up/Down Counter

This block is a synchronous sixteen-state counter. It counts in plain binary, in reflected Gray code or in decimal (0 to 9). It counts up or down, and a one-bit terminal flag pulses when a count wraps. The state register doubles as the count value and is visible on `state_code`. Each clock edge with the enable high takes one step. The step is chosen by a 3-bit input vector formed as `{cnt_type[1:0], cnt_up}`.

A short chain of hidden ownership states is woven into the state graph. These states can only be walked by one secret sequence of input vectors, and only when that sequence starts from the zero state. While the machine sits in a hidden state, it behaves exactly like the ordinary state that the hidden state stands in for. This holds for every vector except the next key vector. For any history other than the complete key, the terminal flag therefore matches that of the plain counter. The hidden states show up only as distinct state codes (`1_0xxx`). After the last hidden state, an extra flag pulse appears that the owner can use as proof. The key length is a parameter from 2 to 6 vectors; a shorter key uses the leading vectors of the same key.

Top module: `wm_mode_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next state is `state_code` = 0 and `term_flag` = 0, even when `cnt_en` is high.
- R2: An edge with `cnt_en` low keeps `state_code` unchanged and drives `term_flag` to 0.
- R3: Type 00 (binary) moves the code by +1 (`cnt_up`=1) or -1 (`cnt_up`=0), modulo 16. The flag pulses on the step from 14 to 15 when counting up, and from 1 to 0 when counting down.
- R4: Type 01 (Gray) keeps `state_code` equal to the Gray encoding of a count, and steps that count by +1 or -1 modulo 16. The flag pulses when counting up from count 14 (code 9) to count 15 (code 8), and when counting down from code 1 to code 0.
- R5: Type 10 (decimal) counts 0 to 9 and wraps between 9 and 0. The flag pulses when counting up from 8 to 9 and when counting down from 1 to 0. From codes 10 to 15, either direction goes to 0 with no pulse.
- R6: Type 11 sends the machine to code 0 with no pulse. The only exception is leaving the last hidden state, where R9 applies.
- R7: Starting from code 0, the key vectors 001, 011, 101, 010, 000, 100 (each written `{type, up}`), applied in that order on enabled edges, step the code through 16, 17, 18, and so on. Hidden state number i has code 16+i-1. A hidden state is entered only from its predecessor: the first one only from code 0.
- R8: At any edge where the vector is not the next key vector, a hidden state moves exactly as its shadow would. Its shadow is the ordinary state the plain counter would have reached with the same key prefix. A stream that never completes the key gives the same flag stream as the plain counter.
- R9: The first enabled edge that leaves the last hidden state drives `term_flag` to 1. The next state follows that state's shadow.
- R10: With `SIG_LEN` = L (2 to 6), only the first L key vectors are used, and the hidden codes stay in the range 16 to 16+L-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Step enable |
| cnt_type | input | 2 | Counting mode: 00 binary, 01 Gray, 10 decimal, 11 clear |
| cnt_up | input | 1 | 1 counts up, 0 counts down |
| term_flag | output | 1 | Registered wrap / ownership pulse |
| state_code | output | 5 | Current state: 0xxxx ordinary, 10xxx hidden |

## Verification
The bench builds two copies that share one stimulus stream. One uses the full six-vector key (`SIG_LEN` = 6) and the other a three-vector key (`SIG_LEN` = 3). A single key walk therefore shows, at the same time, the deep chain continuing and the short chain leaving with its proof pulse and falling back to its shadow successor. The six-vector copy brings every hidden code and every shadow within reach. The three-vector copy exercises the exit from a hidden state that is not the deepest possible one, and shows that a longer history does not re-enter a finished chain. Long random runs, in which the key prefixes occur by chance, compare both copies against a bench model of the plain counter plus chain depth.

// File: rtl/wmc_pkg.sv
// Shared definitions for the watermarked multi-mode counter.
// Assumes a 4-bit ordinary count, a 3-bit step vector {type, up} and
// a key of at most MAX_SIG vectors, packed with the first vector in
// the most significant position.
package wmc_pkg;

    localparam int VEC_W   = 3;
    localparam int BASE_W  = 4;
    localparam int CODE_W  = BASE_W + 1;
    localparam int MAX_SIG = 6;
    localparam int KEY_W   = MAX_SIG * VEC_W;
    localparam int NUM_MODES = 3;
    localparam int IDX_W   = $clog2(MAX_SIG);
    localparam logic [BASE_W-1:0] BCD_TOP = BASE_W'(9);

    typedef enum logic [1:0] {
        MODE_BIN   = 2'b00,
        MODE_GRAY  = 2'b01,
        MODE_DEC   = 2'b10,
        MODE_CLEAR = 2'b11
    } mode_e;

    typedef struct packed {
        logic [BASE_W-1:0] nxt;
        logic              pulse;
    } step_t;

    localparam logic [KEY_W-1:0] DEFAULT_KEY =
        {3'b001, 3'b011, 3'b101, 3'b010, 3'b000, 3'b100};

    // Pick vector j (0 = first applied) out of a packed key.
    function automatic logic [VEC_W-1:0] key_vec(input logic [KEY_W-1:0] key, input int j);
        return key[(MAX_SIG-1-j)*VEC_W +: VEC_W];
    endfunction

    // Gray code to binary weight.
    function automatic logic [BASE_W-1:0] gray_to_bin(input logic [BASE_W-1:0] g);
        logic [BASE_W-1:0] b;
        b[BASE_W-1] = g[BASE_W-1];
        for (int i = BASE_W-2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    // Binary weight to Gray code.
    function automatic logic [BASE_W-1:0] bin_to_gray(input logic [BASE_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    // One binary step with its wrap pulse.
    function automatic step_t bin_step(input logic [BASE_W-1:0] s, input logic up);
        step_t r;
        if (up) begin
            r.nxt   = s + BASE_W'(1);
            r.pulse = (s == BASE_W'(14));
        end else begin
            r.nxt   = s - BASE_W'(1);
            r.pulse = (s == BASE_W'(1));
        end
        return r;
    endfunction

    // One Gray step: decode, move the weight, re-encode.
    function automatic step_t gray_step(input logic [BASE_W-1:0] s, input logic up);
        step_t r;
        logic [BASE_W-1:0] w;
        w = gray_to_bin(s);
        if (up) begin
            r.pulse = (w == BASE_W'(14));
            w       = w + BASE_W'(1);
        end else begin
            r.pulse = (w == BASE_W'(1));
            w       = w - BASE_W'(1);
        end
        r.nxt = bin_to_gray(w);
        return r;
    endfunction

    // One decimal step; codes above nine fall back to zero.
    function automatic step_t dec_step(input logic [BASE_W-1:0] s, input logic up);
        step_t r;
        if (s > BCD_TOP) begin
            r.nxt   = '0;
            r.pulse = 1'b0;
        end else if (up) begin
            r.nxt   = (s == BCD_TOP) ? '0 : s + BASE_W'(1);
            r.pulse = (s == BASE_W'(8));
        end else begin
            r.nxt   = (s == '0) ? BCD_TOP : s - BASE_W'(1);
            r.pulse = (s == BASE_W'(1));
        end
        return r;
    endfunction

    // Full plain-counter step for a vector; used only to derive shadows.
    function automatic step_t plain_step(input logic [BASE_W-1:0] s, input logic [VEC_W-1:0] v);
        step_t r;
        case (mode_e'(v[VEC_W-1:1]))
            MODE_BIN:  r = bin_step(s, v[0]);
            MODE_GRAY: r = gray_step(s, v[0]);
            MODE_DEC:  r = dec_step(s, v[0]);
            default:   r = '0;
        endcase
        return r;
    endfunction

    // Ordinary state reached from zero after key vectors 0..idx.
    function automatic logic [BASE_W-1:0] key_shadow(input logic [KEY_W-1:0] key, input int idx);
        logic [BASE_W-1:0] s;
        step_t r;
        s = '0;
        for (int j = 0; j <= idx; j++) begin
            r = plain_step(s, key_vec(key, j));
            s = r.nxt;
        end
        return s;
    endfunction

endpackage

// File: rtl/wmc_mode_step.sv
// Next ordinary state and wrap pulse for one counting mode.
// MODE selects binary (0), Gray (1) or decimal (2); the block is purely
// combinational and assumes a 4-bit ordinary state at its input.
module wmc_mode_step
    import wmc_pkg::*;
#(
    parameter int MODE = 0
) (
    input  logic [BASE_W-1:0] base_state,
    input  logic              up,
    output logic [BASE_W-1:0] nxt_state,
    output logic              pulse
);

    step_t res;

    // Variant chosen at elaboration by the mode number.
    if (MODE == 0) begin : g_bin
        assign res = bin_step(base_state, up);
    end else if (MODE == 1) begin : g_gray
        assign res = gray_step(base_state, up);
    end else begin : g_dec
        assign res = dec_step(base_state, up);
    end

    assign nxt_state = res.nxt;
    assign pulse     = res.pulse;

endmodule

// File: rtl/wmc_chain_map.sv
// Hidden-state overlay. It maps the current code to the ordinary state
// whose edges apply (the shadow), decides whether this step takes a
// chain edge, and flags the last hidden state.
// Assumes SIG_LEN in 2..MAX_SIG and no key vector with type 11.
module wmc_chain_map
    import wmc_pkg::*;
#(
    parameter int               SIG_LEN = MAX_SIG,
    parameter logic [KEY_W-1:0] KEY     = DEFAULT_KEY
) (
    input  logic [CODE_W-1:0] cur_code,
    input  logic [VEC_W-1:0]  vec,
    output logic [BASE_W-1:0] base_state,
    output logic              take_chain,
    output logic [CODE_W-1:0] chain_code,
    output logic              at_last
);

    localparam int TBL_N = 2 ** IDX_W;
    localparam logic [IDX_W-1:0]  LAST_IDX   = IDX_W'(SIG_LEN - 1);
    localparam logic [CODE_W-1:0] CHAIN_BASE = CODE_W'(1) << BASE_W;
    localparam logic [VEC_W-1:0]  FIRST_VEC  = key_vec(KEY, 0);

    logic [BASE_W-1:0] shadow_tbl [TBL_N];
    logic [VEC_W-1:0]  adv_vec    [TBL_N];
    logic [TBL_N-1:0]  adv_ok;

    logic             in_chain;
    logic             idx_valid;
    logic [IDX_W-1:0] idx;

    // Per hidden slot: shadow state and the vector that advances it.
    for (genvar j = 0; j < TBL_N; j++) begin : g_slot
        if (j < SIG_LEN) begin : g_used
            assign shadow_tbl[j] = key_shadow(KEY, j);
        end else begin : g_unused
            assign shadow_tbl[j] = '0;
        end
        if (j + 1 < SIG_LEN) begin : g_adv
            assign adv_vec[j] = key_vec(KEY, j + 1);
            assign adv_ok[j]  = 1'b1;
        end else begin : g_noadv
            assign adv_vec[j] = '0;
            assign adv_ok[j]  = 1'b0;
        end
    end

    assign in_chain  = cur_code[CODE_W-1];
    assign idx       = cur_code[IDX_W-1:0];
    assign idx_valid = in_chain && (idx <= LAST_IDX);
    assign at_last   = in_chain && (idx == LAST_IDX);

    // Choose which ordinary state's edges drive this step.
    always_comb begin
        if (!in_chain)      base_state = cur_code[BASE_W-1:0];
        else if (idx_valid) base_state = shadow_tbl[idx];
        else                base_state = '0;
    end

    // Chain edges: entry from zero, or one slot deeper on the key.
    always_comb begin
        if (!in_chain) begin
            take_chain = (cur_code == '0) && (vec == FIRST_VEC);
            chain_code = CHAIN_BASE;
        end else begin
            take_chain = idx_valid && adv_ok[idx] && (vec == adv_vec[idx]);
            chain_code = CHAIN_BASE + CODE_W'(idx) + CODE_W'(1);
        end
    end

endmodule

// File: rtl/wmc_state_reg.sv
// State and flag register with synchronous active-low reset.
// Reset wins over enable; an idle edge holds the code and clears the flag.
module wmc_state_reg
    import wmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic [CODE_W-1:0] nxt_code,
    input  logic              nxt_flag,
    output logic [CODE_W-1:0] code_q,
    output logic              flag_q
);

    // Capture the chosen step, or hold with the flag low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            flag_q <= 1'b0;
        end else if (step_en) begin
            code_q <= nxt_code;
            flag_q <= nxt_flag;
        end else begin
            flag_q <= 1'b0;
        end
    end

endmodule

// File: rtl/wm_mode_counter.sv
// Top of the watermarked multi-mode counter. The three mode steppers run
// in parallel on the shadow of the current code; the mode input selects
// one, and the chain overlay can replace the result with a hidden-state
// code. The flag is the mode pulse, or the proof pulse on leaving the
// last hidden state.
module wm_mode_counter
    import wmc_pkg::*;
#(
    parameter int               SIG_LEN = MAX_SIG,
    parameter logic [KEY_W-1:0] KEY     = DEFAULT_KEY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic [1:0]        cnt_type,
    input  logic              cnt_up,
    output logic              term_flag,
    output logic [CODE_W-1:0] state_code
);

    logic [VEC_W-1:0]  vec;
    logic [BASE_W-1:0] base_state;
    logic              take_chain;
    logic [CODE_W-1:0] chain_code;
    logic              at_last;
    logic [BASE_W-1:0] step_nxt   [NUM_MODES];
    logic [NUM_MODES-1:0] step_pulse;
    logic [BASE_W-1:0] plain_nxt;
    logic              plain_pulse;
    logic [CODE_W-1:0] nxt_code;
    logic              nxt_flag;

    assign vec = {cnt_type, cnt_up};

    wmc_chain_map #(.SIG_LEN(SIG_LEN), .KEY(KEY)) u_chain (
        .cur_code   (state_code),
        .vec        (vec),
        .base_state (base_state),
        .take_chain (take_chain),
        .chain_code (chain_code),
        .at_last    (at_last)
    );

    // One stepper per counting mode.
    for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
        wmc_mode_step #(.MODE(m)) u_step (
            .base_state (base_state),
            .up         (cnt_up),
            .nxt_state  (step_nxt[m]),
            .pulse      (step_pulse[m])
        );
    end

    // Mode select; the clear type lands on zero without a pulse.
    always_comb begin
        case (mode_e'(cnt_type))
            MODE_BIN:  begin plain_nxt = step_nxt[0]; plain_pulse = step_pulse[0]; end
            MODE_GRAY: begin plain_nxt = step_nxt[1]; plain_pulse = step_pulse[1]; end
            MODE_DEC:  begin plain_nxt = step_nxt[2]; plain_pulse = step_pulse[2]; end
            default:   begin plain_nxt = '0;          plain_pulse = 1'b0;          end
        endcase
    end

    // Overlay the chain edge and the proof pulse.
    always_comb begin
        nxt_code = take_chain ? chain_code : {1'b0, plain_nxt};
        nxt_flag = plain_pulse | at_last;
    end

    wmc_state_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (cnt_en),
        .nxt_code (nxt_code),
        .nxt_flag (nxt_flag),
        .code_q   (state_code),
        .flag_q   (term_flag)
    );

endmodule

// File: rtl/wmc_checker.sv
// Temporal checks for wm_mode_counter, attached by bind below.
module wmc_checker
    import wmc_pkg::*;
#(
    parameter int SIG_LEN = MAX_SIG
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_en,
    input logic [1:0]        cnt_type,
    input logic              cnt_up,
    input logic              term_flag,
    input logic [CODE_W-1:0] state_code
);

    localparam logic [CODE_W-1:0] FIRST_CODE = CODE_W'(1) << BASE_W;
    localparam logic [CODE_W-1:0] LAST_CODE  = FIRST_CODE + CODE_W'(SIG_LEN - 1);
    localparam logic [IDX_W-1:0]  LAST_IDX   = IDX_W'(SIG_LEN - 1);

    logic unused_up;
    assign unused_up = cnt_up;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (state_code == '0 && !term_flag));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> ($stable(state_code) && !term_flag));

    // R5
    dec_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && cnt_type == 2'b10 && !state_code[CODE_W-1] && state_code[BASE_W-1:0] > BASE_W'(9))
        |=> (state_code == '0 && !term_flag));

    // R6
    clear_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && cnt_type == 2'b11) |=> (state_code == '0));

    // R7
    chain_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code[CODE_W-1] && !$stable(state_code))
        |-> (($past(state_code) == state_code - CODE_W'(1)) ||
             (state_code == FIRST_CODE && $past(state_code) == '0)));

    // R9
    last_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && state_code == LAST_CODE) |=> term_flag);

    // R10
    chain_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_code[CODE_W-1] |-> (state_code[IDX_W-1:0] <= LAST_IDX && state_code[BASE_W-1] == 1'b0));

endmodule

bind wm_mode_counter wmc_checker #(.SIG_LEN(SIG_LEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_en     (cnt_en),
    .cnt_type   (cnt_type),
    .cnt_up     (cnt_up),
    .term_flag  (term_flag),
    .state_code (state_code)
);

// File: tb/sim_wm_mode_counter.sv
module sim_wm_mode_counter;

    localparam int CLK_PERIOD = 10;
    localparam int LEN_A = 6;
    localparam int LEN_B = 3;
    localparam logic [17:0] KEY = 18'b001_011_101_010_000_100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0;
    logic [1:0] cnt_type = 2'b00;
    logic       cnt_up = 1'b0;
    logic       fa, fb;
    logic [4:0] ca, cb;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    logic [3:0] ps = 4'd0;
    int         da = 0;
    int         db = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wm_mode_counter #(.SIG_LEN(LEN_A)) u0 (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_type(cnt_type),
        .cnt_up(cnt_up), .term_flag(fa), .state_code(ca));

    wm_mode_counter #(.SIG_LEN(LEN_B)) u1 (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_type(cnt_type),
        .cnt_up(cnt_up), .term_flag(fb), .state_code(cb));

    function automatic logic [2:0] kv(input int j);
        return KEY[(5-j)*3 +: 3];
    endfunction

    function automatic logic [3:0] g2b(input logic [3:0] g);
        logic [3:0] b;
        b[3] = g[3];
        b[2] = b[3] ^ g[2];
        b[1] = b[2] ^ g[1];
        b[0] = b[1] ^ g[0];
        return b;
    endfunction

    // Plain counter reference: {pulse, next}.
    function automatic logic [4:0] ref_plain(input logic [3:0] s, input logic [2:0] v);
        logic [3:0] w;
        logic [3:0] n;
        logic       p;
        case (v[2:1])
            2'b00: begin
                n = v[0] ? s + 4'd1 : s - 4'd1;
                p = v[0] ? (s == 4'd14) : (s == 4'd1);
            end
            2'b01: begin
                w = g2b(s);
                p = v[0] ? (w == 4'd14) : (w == 4'd1);
                w = v[0] ? w + 4'd1 : w - 4'd1;
                n = w ^ (w >> 1);
            end
            2'b10: begin
                if (s > 4'd9) begin n = 4'd0; p = 1'b0; end
                else if (v[0]) begin n = (s == 4'd9) ? 4'd0 : s + 4'd1; p = (s == 4'd8); end
                else begin n = (s == 4'd0) ? 4'd9 : s - 4'd1; p = (s == 4'd1); end
            end
            default: begin n = 4'd0; p = 1'b0; end
        endcase
        return {p, n};
    endfunction

    function automatic int ref_depth(input int d, input int len, input logic [3:0] s, input logic [2:0] v);
        if (d == 0) return (s == 4'd0 && v == kv(0)) ? 1 : 0;
        if (d < len && v == kv(d)) return d + 1;
        return 0;
    endfunction

    function automatic logic [4:0] code_of(input int d, input logic [3:0] s);
        return (d == 0) ? {1'b0, s} : 5'(16 + d - 1);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // One clock step with model update and comparison on both copies.
    task automatic step(input logic en, input logic [2:0] v, input string tag);
        logic [4:0] pr;
        logic [3:0] nps;
        logic       efa, efb, chain_a, chain_b;
        int         nda, ndb;
        @(negedge clk);
        cnt_en = en;
        {cnt_type, cnt_up} = v;
        pr = ref_plain(ps, v);
        chain_a = en && (da == LEN_A);
        chain_b = en && (db == LEN_B);
        if (en) begin
            nps = pr[3:0];
            efa = pr[4] | chain_a;
            efb = pr[4] | chain_b;
            nda = ref_depth(da, LEN_A, ps, v);
            ndb = ref_depth(db, LEN_B, ps, v);
        end else begin
            nps = ps; efa = 1'b0; efb = 1'b0; nda = da; ndb = db;
        end
        @(posedge clk);
        #1;
        ps = nps; da = nda; db = ndb;
        check({tag, " code"}, 32'(ca), 32'(code_of(da, ps)));
        check({tag, " / R10 short key code"}, 32'(cb), 32'(code_of(db, ps)));
        check(chain_a ? "R9 proof pulse" : "R8 flag vs plain counter", 32'(fa), 32'(efa));
        check(chain_b ? "R9 proof pulse / R10" : "R8 flag vs plain counter / R10", 32'(fb), 32'(efb));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cnt_en = 1'b1;
        {cnt_type, cnt_up} = 3'b001;
        @(posedge clk);
        #1;
        ps = 4'd0; da = 0; db = 0;
        check("R1 reset code", 32'(ca), 32'd0);
        check("R1 reset flag", 32'(fa), 32'd0);
        check("R1 reset code / R10", 32'(cb), 32'd0);
        check("R1 reset flag / R10", 32'(fb), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        cnt_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [2:0] rv;
        logic       ren;
        void'($urandom(32'd20240611));
        do_reset();

        // R3 binary both directions, including both wraps
        for (int i = 0; i < 17; i++) step(1'b1, 3'b001, "R3 binary up");
        for (int i = 0; i < 3; i++)  step(1'b1, 3'b000, "R3 binary down");

        // R4 Gray both directions
        do_reset();
        for (int i = 0; i < 17; i++) step(1'b1, 3'b011, "R4 gray up");
        for (int i = 0; i < 17; i++) step(1'b1, 3'b010, "R4 gray down");

        // R5 decimal both directions and codes above nine
        do_reset();
        for (int i = 0; i < 11; i++) step(1'b1, 3'b101, "R5 decimal up");
        for (int i = 0; i < 11; i++) step(1'b1, 3'b100, "R5 decimal down");
        do_reset();
        for (int i = 0; i < 12; i++) step(1'b1, 3'b001, "R3 binary up");
        step(1'b1, 3'b101, "R5 code 12 decimal up");
        for (int i = 0; i < 13; i++) step(1'b1, 3'b001, "R3 binary up");
        step(1'b1, 3'b100, "R5 code 13 decimal down");

        // R6 clear type and R2 idle hold
        for (int i = 0; i < 5; i++) step(1'b1, 3'b011, "R4 gray up");
        step(1'b1, 3'b110, "R6 clear");
        for (int i = 0; i < 3; i++) step(1'b1, 3'b001, "R3 binary up");
        step(1'b0, 3'b001, "R2 idle hold");
        step(1'b0, 3'b111, "R2 idle hold");

        // R7 full key walk, then R9 proof pulse on the next step
        do_reset();
        step(1'b1, kv(0), "R7 key walk");
        check("R7 first hidden code", 32'(ca), 32'h10);
        for (int j = 1; j < 6; j++) step(1'b1, kv(j), "R7 key walk");
        check("R7 last hidden code", 32'(ca), 32'h15);
        step(1'b1, 3'b001, "R9 leave last hidden state");
        check("R9 proof pulse", 32'(fa), 32'd1);
        check("R9 shadow successor", 32'(ca), 32'h04);

        // R2 idle hold inside the chain, then resume
        do_reset();
        step(1'b1, kv(0), "R7 key walk");
        step(1'b1, kv(1), "R7 key walk");
        step(1'b0, kv(2), "R2 hold in chain");
        for (int j = 2; j < 6; j++) step(1'b1, kv(j), "R7 key walk after hold");
        step(1'b1, 3'b110, "R9 leave by clear");

        // R8 wrong vector mid-chain leaves along the shadow edge
        do_reset();
        step(1'b1, kv(0), "R7 key walk");
        step(1'b1, kv(1), "R7 key walk");
        step(1'b1, 3'b000, "R8 chain exit");
        check("R8 exit to shadow successor", 32'(ca), 32'h02);

        // R7 no entry when the first vector is not applied at zero
        do_reset();
        step(1'b1, 3'b001, "R3 binary up");
        step(1'b1, kv(1), "R7 no entry off zero");
        step(1'b1, kv(2), "R7 no entry off zero");

        // R1 reset inside the chain
        do_reset();
        step(1'b1, kv(0), "R7 key walk");
        step(1'b1, kv(1), "R7 key walk");
        do_reset();

        // R8 random histories, key prefixes occasionally injected
        for (int i = 0; i < 4000; i++) begin
            if ((i % 250) == 0) begin
                for (int k = 0; k < 6; k++) step(1'b1, 3'b110, "R6 clear");
                for (int j = 0; j < int'($urandom_range(0, 6)); j++)
                    step(1'b1, kv(j), "R7 random key prefix");
            end
            rv  = 3'($urandom_range(0, 7));
            ren = ($urandom_range(0, 9) != 0);
            step(ren, rv, "R8 random");
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule